// File: doc/BRIEF.md
# OTP fuse controller sequencer

This block is a register-mapped sequencer that stands between a simple single-cycle register bus and a one-time-programmable fuse array. Software raises a power request in a configuration register and waits for the power-good bit in the status register. It then launches commands through a control register. A read command copies one fuse word into a shadow array that the bus reads directly. A program command ORs the write-data register into a fuse word and then reads the word back to verify it. A lock-program command does the same and, if it succeeds, bars later programming of that word.

Each command occupies the array for a number of cycles taken from configuration fields. Per-word error flags record refused commands, and per-word disturbed flags record failed programs. Both flag sets are packed 32 words to a bank. Fuse bits can only be set, so a program that cannot reach the requested value is reported as a failure and is never retried.

Top module: `otp_fuse_ctrl`

## Requirements
- R1: Writing 1 to config bit 0 (offset 0x000) makes status bit 5 (offset 0x00C) rise after exactly PWR_DELAY+1 clock edges, and writing 0 makes it fall after the same count. While power is fully off, status bits 2:0 read 0. During either power transition they read 1. When powered and idle they read 2.
- R2: A control write (offset 0x004) is refused when the array is not powered and idle, and busy does not rise. A refused write sets error flag bit idx[4:0] in the error bank at 0x034 + 4·(idx>>5). Error flags never clear while out of reset.
- R3: A control write with bit 8 clear is a read of word idx (bits 7:0 hold idx). It holds status bit 3 (busy) for exactly RD_BASE + cfg[8:7] cycles (3 + cfg[8:7] by default). Afterwards the fuse word is readable at 0x200 + 4·idx.
- R4: A control write with bit 8 set is a program of word idx. The fuse becomes old | wdata, where wdata is the register at 0x008. Busy lasts PGM_BASE + cfg[6:3] + 1 cycles (5 + cfg[6:3] by default), and the last of these is a verify read that follows the pulse.
- R5: Status bit 4 is set when the verify read lacks any requested bit, or when the fault input was high during any pulse cycle. A failure also sets disturbed flag bit idx[4:0] in the bank at 0x01C + 4·(idx>>5). Status bit 4 clears when the next program is accepted.
- R6: Control bits 9 and 8 both set make a lock program. It programs like R4, and if it passes, later program commands to that word are refused as in R2. Reads of the word still work.
- R7: Config bits 8:0 read back as written: bit 0 power request, 2:1 frequency, 6:3 pulse width, 8:7 read timing. Bits 31:9 read 0.
- R8: Status bits 2:0 read 3 during a read, 4 during a program pulse and 5 during verify. Busy is never high while power is down.
- R9: Bus writes to the shadow array are ignored. Shadow words change only through read commands.
- R10: After reset, status, config, the shadow array and all flags read 0.
- R11: Clearing the power request during a command lets the command run to completion. Power then falls PWR_DELAY+1 edges after busy drops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busSel | input | 1 | Register access strobe |
| busWrite | input | 1 | 1 = write, 0 = read |
| busAddr | input | 12 | Byte address of the register |
| busWData | input | 32 | Write data |
| busRData | output | 32 | Read data, combinational from busAddr |
| fuseIdx | output | IDX_W | Fuse word under access |
| fuseRdEn | output | 1 | Array read enable |
| fuseRdData | input | 32 | Array read data for fuseIdx |
| fusePgmEn | output | 1 | Program pulse active |
| fusePgmMask | output | 32 | Bits to set during the pulse |
| fuseFault | input | 1 | Fault indication during a pulse |

## Verification
Programs are driven onto blank words, onto words with set bits where the request holds zeros, onto all-ones words and with an all-zero value. Following each with a read separates true OR accumulation from overwriting. Words in both flag banks are used, so a wrong bank or bit slice shows up in the flag registers. Three failing programs are compared against a passing one to tell the verify-readback path from the fault-input path: one hits a stuck fuse bit, one runs with the fault input held high, and one is refused because the word is locked. Commands sent while powered off, while busy, and during a power drop show whether acceptance is gated by power and busy, and not by the request bit alone.

// File: rtl/otp_ctrl_pkg.sv
`timescale 1ns/1ps
package otp_ctrl_pkg;
  localparam int unsigned BUS_AW = 12;

  localparam logic [BUS_AW-1:0] OFS_CFG    = 12'h000;
  localparam logic [BUS_AW-1:0] OFS_CMD    = 12'h004;
  localparam logic [BUS_AW-1:0] OFS_WDATA  = 12'h008;
  localparam logic [BUS_AW-1:0] OFS_STAT   = 12'h00C;
  localparam logic [BUS_AW-1:0] OFS_DIST   = 12'h01C;
  localparam logic [BUS_AW-1:0] OFS_ERR    = 12'h034;
  localparam logic [BUS_AW-1:0] OFS_SHADOW = 12'h200;

  typedef enum logic [2:0] {
    MODE_OFF    = 3'd0,
    MODE_PWRSEQ = 3'd1,
    MODE_IDLE   = 3'd2,
    MODE_READ   = 3'd3,
    MODE_PGM    = 3'd4,
    MODE_VERIFY = 3'd5
  } mode_e;

  // packed MSB first: register image {rdTime[8:7], pulse[6:3], freq[2:1], pwrReq[0]}
  typedef struct packed {
    logic [1:0] rdTime;
    logic [3:0] pulse;
    logic [1:0] freq;
    logic       pwrReq;
  } cfg_t;

  typedef struct packed {
    logic shadowWe;
    logic pgmStart;
    logic setErr;
    logic failDone;
    logic passLock;
  } ctl_strobe_t;
endpackage

// File: rtl/otp_ctrl_fsm.sv
`timescale 1ns/1ps
module otp_ctrl_fsm
  import otp_ctrl_pkg::*;
#(
  parameter int unsigned NUM_WORDS = 64,
  parameter int unsigned PWR_DELAY = 4,
  parameter int unsigned RD_BASE   = 3,
  parameter int unsigned PGM_BASE  = 4,
  localparam int unsigned IDX_W    = $clog2(NUM_WORDS)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgPwrReq,
  input  logic [3:0]       cfgPulse,
  input  logic [1:0]       cfgRdTime,
  input  logic [31:0]      wdata,
  input  logic             cmdWr,
  input  logic [IDX_W-1:0] cmdIdx,
  input  logic             cmdPgm,
  input  logic             cmdLock,
  input  logic             cmdLocked,
  input  logic [31:0]      fuseRdData,
  input  logic             fuseFault,
  output logic [IDX_W-1:0] fuseIdx,
  output logic             fuseRdEn,
  output logic             fusePgmEn,
  output logic [31:0]      fusePgmMask,
  output logic             busy,
  output logic             pwrUp,
  output logic [2:0]       mode,
  output ctl_strobe_t      strb,
  output logic [IDX_W-1:0] strbIdx,
  output logic [IDX_W-1:0] errIdx
);
  localparam int unsigned MAX_A = (PWR_DELAY > PGM_BASE + 15) ? PWR_DELAY : PGM_BASE + 15;
  localparam int unsigned MAX_C = (MAX_A > RD_BASE + 3) ? MAX_A : RD_BASE + 3;
  localparam int unsigned CNT_W = $clog2(MAX_C + 1);

  typedef enum logic [2:0] {S_OFF, S_PWRUP, S_IDLE, S_PWRDN, S_READ, S_PGM, S_VERIFY} state_e;

  state_e           state;
  logic [CNT_W-1:0] cnt;
  logic [IDX_W-1:0] cmdIdxQ;
  logic [31:0]      cmdDataQ;
  logic             lockQ;
  logic             faultSeen;
  logic             accept;
  logic             verifyFail;

  assign accept     = cmdWr && (state == S_IDLE) && !(cmdPgm && cmdLocked);
  assign verifyFail = faultSeen || ((fuseRdData & cmdDataQ) != cmdDataQ);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= S_OFF;
      cnt       <= '0;
      cmdIdxQ   <= '0;
      cmdDataQ  <= '0;
      lockQ     <= 1'b0;
      faultSeen <= 1'b0;
    end else begin
      case (state)
        S_OFF: if (cfgPwrReq) begin
          state <= S_PWRUP;
          cnt   <= CNT_W'(PWR_DELAY - 1);
        end
        S_PWRUP: if (cnt == '0) state <= S_IDLE; else cnt <= cnt - 1'b1;
        S_IDLE: begin
          if (accept) begin
            cmdIdxQ   <= cmdIdx;
            cmdDataQ  <= wdata;
            lockQ     <= cmdLock && cmdPgm;
            faultSeen <= 1'b0;
            if (cmdPgm) begin
              state <= S_PGM;
              cnt   <= CNT_W'(PGM_BASE) + CNT_W'(cfgPulse) - CNT_W'(1);
            end else begin
              state <= S_READ;
              cnt   <= CNT_W'(RD_BASE) + CNT_W'(cfgRdTime) - CNT_W'(1);
            end
          end else if (!cfgPwrReq) begin
            state <= S_PWRDN;
            cnt   <= CNT_W'(PWR_DELAY - 1);
          end
        end
        S_PWRDN: if (cnt == '0) state <= S_OFF; else cnt <= cnt - 1'b1;
        S_READ:  if (cnt == '0) state <= S_IDLE; else cnt <= cnt - 1'b1;
        S_PGM: begin
          if (fuseFault) faultSeen <= 1'b1;
          if (cnt == '0) state <= S_VERIFY; else cnt <= cnt - 1'b1;
        end
        S_VERIFY: state <= S_IDLE;
        default:  state <= S_OFF;
      endcase
    end
  end

  always_comb begin
    strb          = '0;
    strb.shadowWe = (state == S_READ) && (cnt == '0);
    strb.pgmStart = accept && cmdPgm;
    strb.setErr   = cmdWr && !accept;
    strb.failDone = (state == S_VERIFY) && verifyFail;
    strb.passLock = (state == S_VERIFY) && !verifyFail && lockQ;
  end
  assign strbIdx = cmdIdxQ;
  assign errIdx  = cmdIdx;

  assign fuseIdx     = cmdIdxQ;
  assign fuseRdEn    = (state == S_READ) || (state == S_VERIFY);
  assign fusePgmEn   = (state == S_PGM);
  assign fusePgmMask = fusePgmEn ? cmdDataQ : '0;
  assign busy        = (state == S_READ) || (state == S_PGM) || (state == S_VERIFY);
  assign pwrUp       = (state != S_OFF) && (state != S_PWRUP);

  always_comb begin
    case (state)
      S_OFF:    mode = MODE_OFF;
      S_PWRUP,
      S_PWRDN:  mode = MODE_PWRSEQ;
      S_IDLE:   mode = MODE_IDLE;
      S_READ:   mode = MODE_READ;
      S_PGM:    mode = MODE_PGM;
      default:  mode = MODE_VERIFY;
    endcase
  end

  p_busy_powered_r8: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> pwrUp);
  p_refused_stays_idle_r2: assert property (@(posedge clk) disable iff (!rstN)
    (cmdWr && !busy && mode != MODE_IDLE) |=> !busy);
  p_verify_follows_pulse_r4: assert property (@(posedge clk) disable iff (!rstN)
    $fell(fusePgmEn) |-> fuseRdEn);
endmodule

// File: rtl/otp_ctrl_regs.sv
`timescale 1ns/1ps
module otp_ctrl_regs
  import otp_ctrl_pkg::*;
#(
  parameter int unsigned NUM_WORDS = 64,
  localparam int unsigned IDX_W    = $clog2(NUM_WORDS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWrite,
  input  logic [BUS_AW-1:0] busAddr,
  input  logic [31:0]       busWData,
  output logic [31:0]       busRData,
  input  ctl_strobe_t       strb,
  input  logic [IDX_W-1:0]  strbIdx,
  input  logic [IDX_W-1:0]  errIdx,
  input  logic              busy,
  input  logic              pwrUp,
  input  logic [2:0]        mode,
  input  logic [31:0]       fuseRdData,
  output logic              cfgPwrReq,
  output logic [3:0]        cfgPulse,
  output logic [1:0]        cfgRdTime,
  output logic [31:0]       wdata,
  output logic              cmdWr,
  output logic [IDX_W-1:0]  cmdIdx,
  output logic              cmdPgm,
  output logic              cmdLock,
  output logic              cmdLocked
);
  localparam int unsigned NUM_BANKS = (NUM_WORDS + 31) / 32;
  localparam int unsigned PAD_W     = NUM_BANKS * 32;
  localparam logic [BUS_AW-1:0] SH_END = OFS_SHADOW + BUS_AW'(4 * NUM_WORDS);

  cfg_t                        cfgQ;
  logic [31:0]                 wdataQ;
  logic [NUM_WORDS-1:0][31:0]  shadowQ;
  logic [NUM_WORDS-1:0]        errQ;
  logic [NUM_WORDS-1:0]        distQ;
  logic [NUM_WORDS-1:0]        lockQ;
  logic                        failQ;
  logic                        wrEn;
  logic [PAD_W-1:0]            errPad;
  logic [PAD_W-1:0]            distPad;

  assign wrEn      = busSel && busWrite;
  assign cmdWr     = wrEn && (busAddr == OFS_CMD);
  assign cmdIdx    = busWData[IDX_W-1:0];
  assign cmdPgm    = busWData[8];
  assign cmdLock   = busWData[9];
  assign cmdLocked = lockQ[cmdIdx];
  assign cfgPwrReq = cfgQ.pwrReq;
  assign cfgPulse  = cfgQ.pulse;
  assign cfgRdTime = cfgQ.rdTime;
  assign wdata     = wdataQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfgQ   <= '0;
      wdataQ <= '0;
    end else begin
      if (wrEn && busAddr == OFS_CFG)   cfgQ   <= cfg_t'(busWData[8:0]);
      if (wrEn && busAddr == OFS_WDATA) wdataQ <= busWData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) shadowQ <= '0;
    else if (strb.shadowWe) shadowQ[strbIdx] <= fuseRdData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      errQ  <= '0;
      distQ <= '0;
      lockQ <= '0;
      failQ <= 1'b0;
    end else begin
      if (strb.setErr)   errQ[errIdx]    <= 1'b1;
      if (strb.failDone) distQ[strbIdx]  <= 1'b1;
      if (strb.passLock) lockQ[strbIdx]  <= 1'b1;
      if (strb.pgmStart)      failQ <= 1'b0;
      else if (strb.failDone) failQ <= 1'b1;
    end
  end

  assign errPad  = PAD_W'(errQ);
  assign distPad = PAD_W'(distQ);

  always_comb begin
    busRData = '0;
    if (busAddr == OFS_CFG)   busRData = 32'(cfgQ);
    if (busAddr == OFS_WDATA) busRData = wdataQ;
    if (busAddr == OFS_STAT)  busRData = {26'b0, pwrUp, failQ, busy, mode};
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (busAddr == OFS_DIST + BUS_AW'(4 * b)) busRData = distPad[b*32 +: 32];
      if (busAddr == OFS_ERR  + BUS_AW'(4 * b)) busRData = errPad[b*32 +: 32];
    end
    if (busAddr >= OFS_SHADOW && busAddr < SH_END && busAddr[1:0] == 2'b00)
      busRData = shadowQ[IDX_W'((busAddr - OFS_SHADOW) >> 2)];
  end

  p_err_sticky_r2: assert property (@(posedge clk) disable iff (!rstN)
    (errQ & $past(errQ)) == $past(errQ));
  p_fail_marks_word_r5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(failQ) |-> (distQ != '0));
  p_shadow_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    !strb.shadowWe |=> $stable(shadowQ));
endmodule

// File: rtl/otp_fuse_ctrl.sv
`timescale 1ns/1ps
module otp_fuse_ctrl
  import otp_ctrl_pkg::*;
#(
  parameter int unsigned NUM_WORDS = 64,
  parameter int unsigned PWR_DELAY = 4,
  parameter int unsigned RD_BASE   = 3,
  parameter int unsigned PGM_BASE  = 4,
  localparam int unsigned IDX_W    = $clog2(NUM_WORDS)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             busSel,
  input  logic             busWrite,
  input  logic [11:0]      busAddr,
  input  logic [31:0]      busWData,
  output logic [31:0]      busRData,
  output logic [IDX_W-1:0] fuseIdx,
  output logic             fuseRdEn,
  input  logic [31:0]      fuseRdData,
  output logic             fusePgmEn,
  output logic [31:0]      fusePgmMask,
  input  logic             fuseFault
);
  ctl_strobe_t      strb;
  logic [IDX_W-1:0] strbIdx, errIdx, cmdIdx;
  logic             busy, pwrUp, cfgPwrReq, cmdWr, cmdPgm, cmdLock, cmdLocked;
  logic [2:0]       mode;
  logic [3:0]       cfgPulse;
  logic [1:0]       cfgRdTime;
  logic [31:0]      wdata;

  otp_ctrl_regs #(.NUM_WORDS(NUM_WORDS)) u_regs (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWrite(busWrite),
    .busAddr(busAddr), .busWData(busWData), .busRData(busRData),
    .strb(strb), .strbIdx(strbIdx), .errIdx(errIdx),
    .busy(busy), .pwrUp(pwrUp), .mode(mode), .fuseRdData(fuseRdData),
    .cfgPwrReq(cfgPwrReq), .cfgPulse(cfgPulse), .cfgRdTime(cfgRdTime),
    .wdata(wdata), .cmdWr(cmdWr), .cmdIdx(cmdIdx), .cmdPgm(cmdPgm),
    .cmdLock(cmdLock), .cmdLocked(cmdLocked)
  );

  otp_ctrl_fsm #(
    .NUM_WORDS(NUM_WORDS), .PWR_DELAY(PWR_DELAY),
    .RD_BASE(RD_BASE), .PGM_BASE(PGM_BASE)
  ) u_fsm (
    .clk(clk), .rstN(rstN), .cfgPwrReq(cfgPwrReq), .cfgPulse(cfgPulse),
    .cfgRdTime(cfgRdTime), .wdata(wdata), .cmdWr(cmdWr), .cmdIdx(cmdIdx),
    .cmdPgm(cmdPgm), .cmdLock(cmdLock), .cmdLocked(cmdLocked),
    .fuseRdData(fuseRdData), .fuseFault(fuseFault), .fuseIdx(fuseIdx),
    .fuseRdEn(fuseRdEn), .fusePgmEn(fusePgmEn), .fusePgmMask(fusePgmMask),
    .busy(busy), .pwrUp(pwrUp), .mode(mode), .strb(strb),
    .strbIdx(strbIdx), .errIdx(errIdx)
  );
endmodule

// File: tb/otp_fuse_ctrl_tb.sv
`timescale 1ns/1ps
module otp_fuse_ctrl_tb;
  localparam int PWR_DELAY = 4;
  localparam int RD_BUSY   = 3 + 1;      // rdTime = 1
  localparam int PGM_BUSY  = 5 + 2;      // pulse  = 2
  localparam logic [11:0] A_CFG = 12'h000, A_CMD = 12'h004, A_WD = 12'h008,
                          A_ST = 12'h00C, A_DIST0 = 12'h01C, A_ERR0 = 12'h034,
                          A_ERR1 = 12'h038, A_SH = 12'h200;
  // {pgm, idx[5:0], data[31:0], expect[31:0]}
  localparam logic [70:0] VEC [11] = '{
    {1'b1, 6'd0,  32'hA5A5_0001, 32'h0},
    {1'b0, 6'd0,  32'h0,         32'hA5A5_0001},
    {1'b1, 6'd37, 32'h8000_0000, 32'h0},
    {1'b0, 6'd37, 32'h0,         32'h8000_0000},
    {1'b1, 6'd0,  32'h0000_0100, 32'h0},
    {1'b0, 6'd0,  32'h0,         32'hA5A5_0101},
    {1'b1, 6'd63, 32'hFFFF_FFFF, 32'h0},
    {1'b0, 6'd63, 32'h0,         32'hFFFF_FFFF},
    {1'b0, 6'd5,  32'h0,         32'h0},
    {1'b1, 6'd5,  32'h0,         32'h0},
    {1'b0, 6'd5,  32'h0,         32'h0}
  };

  logic clk = 1'b0, rstN = 1'b0, busSel = 1'b0, busWrite = 1'b0, fuseFault = 1'b0;
  logic [11:0] busAddr = '0;
  logic [31:0] busWData = '0, busRData, fuseRdData, fusePgmMask;
  logic [5:0]  fuseIdx;
  logic        fuseRdEn, fusePgmEn;
  logic [31:0] fuseMem [64];
  int nRun = 0, nFail = 0;
  bit done = 0;

  always #10 clk = ~clk;

  otp_fuse_ctrl u_dut (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWrite(busWrite),
    .busAddr(busAddr), .busWData(busWData), .busRData(busRData),
    .fuseIdx(fuseIdx), .fuseRdEn(fuseRdEn), .fuseRdData(fuseRdData),
    .fusePgmEn(fusePgmEn), .fusePgmMask(fusePgmMask), .fuseFault(fuseFault)
  );

  // behavioural fuse array: bits only set; word 10 bit 4 is stuck at 0
  initial for (int i = 0; i < 64; i++) fuseMem[i] = '0;
  always @(posedge clk)
    if (fusePgmEn && !fuseFault)
      fuseMem[fuseIdx] <= fuseMem[fuseIdx] | (fusePgmMask & ((fuseIdx == 6'd10) ? ~32'h10 : ~32'h0));
  assign fuseRdData = fuseMem[fuseIdx];

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic busWr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    busSel = 1'b1; busWrite = 1'b1; busAddr = a; busWData = d;
    @(negedge clk);
    busSel = 1'b0; busWrite = 1'b0;
  endtask

  task automatic busRd(input logic [11:0] a, output logic [31:0] d);
    busAddr = a; busSel = 1'b1; #1; d = busRData; busSel = 1'b0;
  endtask

  // counts negedges (starting now) while status bit 'pos' equals 'val'
  task automatic countWhile(input int pos, input bit val, output int n);
    logic [31:0] s;
    n = 0;
    for (int k = 0; k < 300; k++) begin
      busRd(A_ST, s);
      if (s[pos] != val) break;
      n++;
      @(negedge clk);
    end
  endtask

  initial begin
    #(20 * 100000);
    if (!done) begin
      nRun++; nFail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    int n;
    logic [31:0] errExp;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R10 reset state
    busRd(A_ST, r);          chk("R10 status", r, 32'h0);
    busRd(A_CFG, r);         chk("R10 config", r, 32'h0);
    busRd(A_SH + 12'd4, r);  chk("R10 shadow", r, 32'h0);
    busRd(A_ERR0, r);        chk("R10 error bank", r, 32'h0);

    // R2 command while unpowered: refused, error bank1 bit 8
    busWr(A_CMD, 32'd40);
    busRd(A_ST, r);          chk("R2 no busy when off", {31'b0, r[3]}, 32'h0);
    busRd(A_ERR1, r);        chk("R2 error flag word 40", r, 32'h100);

    // R7 config fields readback, power request still low
    busWr(A_CFG, 32'hFFFF_FE92);
    busRd(A_CFG, r);         chk("R7 config readback", r, 32'h092);
    busRd(A_ST, r);          chk("R1 mode off", {29'b0, r[2:0]}, 32'd0);

    // R1 power up timing
    busWr(A_CFG, 32'h93);
    countWhile(5, 1'b0, n);  chk("R1 power-up delay", n, PWR_DELAY + 1);
    busRd(A_ST, r);          chk("R1 mode idle", {29'b0, r[2:0]}, 32'd2);

    // R3 / R4 table of reads and programs
    foreach (VEC[i]) begin
      if (VEC[i][70]) begin
        busWr(A_WD, VEC[i][63:32]);
        busWr(A_CMD, 32'h100 | 32'(VEC[i][69:64]));
        countWhile(3, 1'b1, n); chk("R4 program busy cycles", n, PGM_BUSY);
        busRd(A_ST, r);         chk("R4 program status fail bit", {31'b0, r[4]}, VEC[i][31:0]);
      end else begin
        busWr(A_CMD, 32'(VEC[i][69:64]));
        countWhile(3, 1'b1, n); chk("R3 read busy cycles", n, RD_BUSY);
        busRd(A_SH + 12'(4 * VEC[i][69:64]), r);
        chk("R3 shadow value", r, VEC[i][31:0]);
      end
    end

    // R8 mode during read, R2 refused while busy
    busWr(A_CMD, 32'd0);
    busRd(A_ST, r);          chk("R8 busy and read mode", {28'b0, r[3:0]}, 32'hB);
    busWr(A_CMD, 32'd2);
    countWhile(3, 1'b1, n);
    errExp = 32'h4;
    busRd(A_ERR0, r);        chk("R2 refused while busy", r, errExp);

    // R5 stuck fuse bit fails verify
    busWr(A_WD, 32'h10);
    busWr(A_CMD, 32'h100 | 32'd10);
    busRd(A_ST, r);          chk("R8 program mode", {29'b0, r[2:0]}, 32'd4);
    countWhile(3, 1'b1, n);
    busRd(A_ST, r);          chk("R5 stuck bit fail", {31'b0, r[4]}, 32'h1);
    busRd(A_DIST0, r);       chk("R5 disturbed word 10", r, 32'h400);

    // R5 fault input during pulse
    busWr(A_WD, 32'hF0);
    fuseFault = 1'b1;
    busWr(A_CMD, 32'h100 | 32'd11);
    countWhile(3, 1'b1, n);
    fuseFault = 1'b0;
    busRd(A_ST, r);          chk("R5 fault fail", {31'b0, r[4]}, 32'h1);
    busRd(A_DIST0, r);       chk("R5 disturbed word 11", r, 32'hC00);
    busWr(A_CMD, 32'd11);
    countWhile(3, 1'b1, n);
    busRd(A_SH + 12'd44, r); chk("R5 faulted word unchanged", r, 32'h0);

    // R5 fail cleared by next accepted program
    busWr(A_WD, 32'h1);
    busWr(A_CMD, 32'h100 | 32'd1);
    countWhile(3, 1'b1, n);
    busRd(A_ST, r);          chk("R5 fail cleared", {31'b0, r[4]}, 32'h0);

    // R6 lock program then refused program
    busWr(A_WD, 32'h55);
    busWr(A_CMD, 32'h300 | 32'd12);
    countWhile(3, 1'b1, n);  chk("R6 lock program busy", n, PGM_BUSY);
    busWr(A_WD, 32'hAA);
    busWr(A_CMD, 32'h100 | 32'd12);
    busRd(A_ST, r);          chk("R6 locked program not started", {31'b0, r[3]}, 32'h0);
    errExp |= 32'h1000;
    busRd(A_ERR0, r);        chk("R6 locked program flagged", r, errExp);
    busWr(A_CMD, 32'd12);
    countWhile(3, 1'b1, n);
    busRd(A_SH + 12'd48, r); chk("R6 locked word still readable", r, 32'h55);

    // R9 shadow not writable from the bus
    busWr(A_SH + 12'd48, 32'hDEAD_BEEF);
    busRd(A_SH + 12'd48, r); chk("R9 shadow write ignored", r, 32'h55);

    // R11 power drop during a program
    busWr(A_WD, 32'h3);
    busWr(A_CMD, 32'h100 | 32'd20);
    busRd(A_ST, r);
    n = r[3] ? 1 : 0;
    busWr(A_CFG, 32'h92);
    begin
      int m;
      countWhile(3, 1'b1, m);
      chk("R11 command completes", n + m + 1, PGM_BUSY);
    end
    countWhile(5, 1'b1, n);  chk("R11 power-down delay", n, PWR_DELAY + 1);
    busRd(A_ST, r);          chk("R1 off after drop", {26'b0, r[5:0]}, 32'h0);
    busWr(A_CFG, 32'h93);
    countWhile(5, 1'b0, n);
    busWr(A_CMD, 32'd20);
    countWhile(3, 1'b1, n);
    busRd(A_SH + 12'd80, r); chk("R11 programmed value kept", r, 32'h3);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule